// File: doc/BRIEF.md
# In-Circuit Programming Mode-Entry Sequencer

This block lets an external programmer steer a target microcontroller into its in-circuit programming mode. It raises a test-mode select line, creates a synchronising event, waits a start-up delay that scales with the target CPU period, and then drives a fixed train of 38 clock pulses on a shared clock/data pin. When the entry window closes, it stops driving that pin so that the serial programming traffic that follows can use it.

Two synchronising variants are supported, chosen per sequence. In the first, the sequencer pulls its reset output low for a fixed time, and the rising edge of reset is the event. In the second, the target has no reset pin; the sequencer waits for a comparator input that reports the supply rising past its threshold. The target CPU period comes in as a count of local clocks. The start-up delay aims at the middle of the allowed range, which is 50 µs plus 256 CPU periods.

Top module: `icp_entry_seq`

## Requirements
- R1: While reset is low and on the first cycle after it is released: tm_o=0, rst_n_o=1, dat_o=0, dat_oe_o=0, busy_o=0, done_o=0.
- R2: When start_i is sampled high in idle, busy_o and tm_o are high from the next cycle and stay high until the window ends. A start_i seen while busy has no effect.
- R3: With mode_vdd_i=0 latched at start, tm_o is held high for TM_SETUP cycles, and then rst_n_o is low for exactly RST_LEN cycles.
- R4: With mode_vdd_i=1 latched at start, rst_n_o never goes low. The event is a rising edge of vdd_ok_i, passed through a two-flop synchroniser, and is seen only after the TM_SETUP cycles. The first pulse follows 3+D cycles after the edge is sampled.
- R5: In the reset variant, the first pulse goes high exactly D cycles after rst_n_o returns high. D = ceil(CLK_HZ/20000) + 256*P, where P is the latched CPU period.
- R6: Exactly 38 pulses are driven on dat_o. Each is high for HALF cycles and then low for HALF cycles, with no gap between them.
- R7: dat_oe_o is high from the first pulse cycle for exactly 4096*P cycles, and dat_o is 0 whenever dat_oe_o is 0.
- R8: done_o is high for one cycle, in the cycle right after the window. busy_o and tm_o are low in that cycle, and the block is idle in the next.
- R9: abort_i sampled high returns the block to idle in the next cycle with every output released. This holds in any state, and abort_i wins over a start_i in the same cycle or a window end in the same cycle.
- R10: cpu_per_i is latched at start, and later changes have no effect. A value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an entry sequence (used in idle only) |
| abort_i | input | 1 | Return to idle, releasing all outputs |
| mode_vdd_i | input | 1 | 0: reset-pulse event, 1: supply-threshold event |
| cpu_per_i | input | CPU_W | Target CPU period in local clocks |
| vdd_ok_i | input | 1 | Asynchronous comparator: supply above threshold |
| tm_o | output | 1 | Test-mode select to target |
| rst_n_o | output | 1 | Active-low reset to target |
| dat_o | output | 1 | Pulse value for the clock/data pin |
| dat_oe_o | output | 1 | Drive enable for the clock/data pin |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion flag |

## Verification
Abort and window completion can fall in the same cycle, as can abort and start. The bench raises abort_i in the final cycle of the 4096-period window, and the next cycle must be idle with no done flag. It also raises start_i and abort_i together in idle, and the block must stay idle. A behavioural timeline model computes every output on every cycle from the cycle count since start, so a done pulse that leaks or a start that slips through shows up at once.

// File: rtl/icp_pkg.sv
// Package: shared state encoding for the programming-mode entry sequencer.
// Assumes: nothing beyond 1800-2017.
package icp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_TM      = 3'd1,
        ST_RSTPUL  = 3'd2,
        ST_WAITVDD = 3'd3,
        ST_STARTUP = 3'd4,
        ST_PULSES  = 3'd5,
        ST_WINEND  = 3'd6,
        ST_DONE    = 3'd7
    } icp_state_e;
endpackage

// File: rtl/icp_vdd_sync.sv
// Module: two-flop synchroniser for the asynchronous supply comparator,
// plus a one-cycle rise indication taken from the synchronised level.
// Assumes: comparator output is glitch-free enough that one edge = one crossing.
module icp_vdd_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic vdd_ok_i,
    output logic rise_o
);
    logic s1, s2, s3;

    // Shift the comparator level through the synchroniser and keep one history bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= vdd_ok_i;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise_o = s2 & ~s3;

    p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/icp_pulse_gen.sv
// Module: produces NPULSE back-to-back pulses of HALF cycles high then HALF
// cycles low while run is held; flags the final cycle of the last pulse.
// Assumes: run is held continuously from the first pulse to last_o.
module icp_pulse_gen #(
    parameter int unsigned HALF   = 2,
    parameter int unsigned NPULSE = 38
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic dat_o,
    output logic last_o
);
    localparam int unsigned HC_W = $clog2(HALF) + 1;
    localparam int unsigned PC_W = $clog2(NPULSE) + 1;

    logic [HC_W-1:0] hc;
    logic            ph;
    logic [PC_W-1:0] pc;

    // Advance the half-period counter, the phase and the pulse index.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            hc <= '0;
            ph <= 1'b0;
            pc <= '0;
        end else if (hc == HC_W'(HALF - 1)) begin
            hc <= '0;
            ph <= ~ph;
            if (ph) pc <= pc + 1'b1;
        end else begin
            hc <= hc + 1'b1;
        end
    end

    assign dat_o  = run & ~ph;
    assign last_o = run & ph & (hc == HC_W'(HALF - 1)) & (pc == PC_W'(NPULSE - 1));

    p_pulse_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pc < PC_W'(NPULSE)));
    p_half_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && hc != '0) |-> (dat_o == $past(dat_o)));
endmodule

// File: rtl/icp_entry_seq.sv
// Module: top of the programming-mode entry sequencer. Raises test mode,
// makes the synchronising event (reset pulse or supply crossing), waits the
// mid-range start-up delay, drives the pulse train and holds the pin until
// the window of 4096 CPU periods ends, then releases it.
// Assumes: vdd_ok_i is asynchronous; cpu_per_i is stable in the start cycle.
module icp_entry_seq #(
    parameter int unsigned CLK_HZ   = 16_000_000,
    parameter int unsigned CPU_W    = 8,
    parameter int unsigned MIN_CPU  = 1,
    parameter int unsigned HALF     = 2,
    parameter int unsigned NPULSE   = 38,
    parameter int unsigned TM_SETUP = 4,
    parameter int unsigned RST_LEN  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic             mode_vdd_i,
    input  logic [CPU_W-1:0] cpu_per_i,
    input  logic             vdd_ok_i,
    output logic             tm_o,
    output logic             rst_n_o,
    output logic             dat_o,
    output logic             dat_oe_o,
    output logic             busy_o,
    output logic             done_o
);
    import icp_pkg::*;

    localparam int unsigned D50   = (CLK_HZ + 19_999) / 20_000;
    localparam int unsigned CNT_W = $clog2(D50 + 4096 * (2 ** CPU_W)) + 1;

    if (longint'(HALF) * 2_000_000_000 < 125 * longint'(CLK_HZ)) begin : g_bad_half
        $error("HALF gives a pulse phase shorter than 62.5 ns");
    end
    if (2 * NPULSE * HALF >= 4096 * MIN_CPU) begin : g_bad_fit
        $error("pulse train does not fit inside the entry window");
    end

    icp_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic [CPU_W-1:0] cpu_q;
    logic             mode_q;
    logic [CNT_W-1:0] dly, win;
    logic             vdd_rise, p_last, p_dat;

    assign dly = CNT_W'(D50) + (CNT_W'(cpu_q) << 8);
    assign win = CNT_W'(cpu_q) << 12;

    icp_vdd_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .vdd_ok_i (vdd_ok_i),
        .rise_o   (vdd_rise)
    );

    icp_pulse_gen #(.HALF(HALF), .NPULSE(NPULSE)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st == ST_PULSES),
        .dat_o  (p_dat),
        .last_o (p_last)
    );

    // Sequence state and the shared phase/window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            cpu_q  <= CPU_W'(1);
            mode_q <= 1'b0;
        end else if (abort_i) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start_i) begin
                    st     <= ST_TM;
                    cnt    <= '0;
                    cpu_q  <= (cpu_per_i == '0) ? CPU_W'(1) : cpu_per_i;
                    mode_q <= mode_vdd_i;
                end
                ST_TM: if (cnt == CNT_W'(TM_SETUP - 1)) begin
                    cnt <= '0;
                    st  <= mode_q ? ST_WAITVDD : ST_RSTPUL;
                end else cnt <= cnt + 1'b1;
                ST_RSTPUL: if (cnt == CNT_W'(RST_LEN - 1)) begin
                    cnt <= '0;
                    st  <= ST_STARTUP;
                end else cnt <= cnt + 1'b1;
                ST_WAITVDD: if (vdd_rise) begin
                    cnt <= '0;
                    st  <= ST_STARTUP;
                end
                ST_STARTUP: if (cnt == dly - 1'b1) begin
                    cnt <= '0;
                    st  <= ST_PULSES;
                end else cnt <= cnt + 1'b1;
                ST_PULSES: begin
                    cnt <= cnt + 1'b1;
                    if (p_last) st <= ST_WINEND;
                end
                ST_WINEND: if (cnt == win - 1'b1) begin
                    cnt <= '0;
                    st  <= ST_DONE;
                end else cnt <= cnt + 1'b1;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the registered state.
    always_comb begin
        busy_o   = (st != ST_IDLE) && (st != ST_DONE);
        tm_o     = busy_o;
        rst_n_o  = (st != ST_RSTPUL);
        dat_oe_o = (st == ST_PULSES) || (st == ST_WINEND);
        dat_o    = p_dat;
        done_o   = (st == ST_DONE);
    end

    p_tm_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> tm_o);
    p_rst_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_n_o |-> (busy_o && !mode_q && !dat_oe_o));
    p_pin_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_oe_o |-> !dat_o);
    p_window_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WINEND) |-> (cnt < win));
    p_done_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
    p_abort_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!busy_o && !done_o && !dat_oe_o && rst_n_o && !tm_o));
endmodule

// File: tb/icp_entry_seq_tb.sv
module icp_entry_seq_tb;
    localparam int CLK_PER = 10;
    localparam int CLK_HZ  = 4_000_000;
    localparam int CPU_W   = 4;
    localparam int HALF    = 2;
    localparam int NP      = 38;
    localparam int TMS     = 4;
    localparam int RSTL    = 8;
    localparam int D50     = 200;   // 50 us at 4 MHz

    logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, abort_i = 1'b0;
    logic mode_vdd_i = 1'b0, vdd_ok_i = 1'b0;
    logic [CPU_W-1:0] cpu_per_i = '0;
    logic tm_o, rst_n_o, dat_o, dat_oe_o, busy_o, done_o;
    int checks = 0, fails = 0, cyc = 0;

    icp_entry_seq #(.CLK_HZ(CLK_HZ), .CPU_W(CPU_W), .MIN_CPU(1), .HALF(HALF),
                    .NPULSE(NP), .TM_SETUP(TMS), .RST_LEN(RSTL)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
        .mode_vdd_i(mode_vdd_i), .cpu_per_i(cpu_per_i), .vdd_ok_i(vdd_ok_i),
        .tm_o(tm_o), .rst_n_o(rst_n_o), .dat_o(dat_o), .dat_oe_o(dat_oe_o),
        .busy_o(busy_o), .done_o(done_o));

    always #(CLK_PER/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150_000) begin
            checks++; fails++;
            $display("FAIL R2 watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input int t, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0d actual=%0b expected=%0b", tag, t, act, exp);
        end
    endtask

    // Timeline model: {tm, rst_n, dat, oe, busy, done} at cycle t after the start edge.
    function automatic logic [5:0] expv(int t, int mode, int tp, int win);
        logic busy, rstn, oe, dat, done;
        busy = (t >= 1) && (t <= tp + win - 1);
        rstn = !((mode == 0) && (t >= TMS + 1) && (t <= TMS + RSTL));
        oe   = (t >= tp) && (t <= tp + win - 1);
        dat  = oe && ((t - tp) < 2 * NP * HALF) && ((((t - tp) / HALF) % 2) == 0);
        done = (t == tp + win);
        return {busy, rstn, dat, oe, busy, done};
    endfunction

    task automatic check_idle(input string tag, input int t);
        chk(tag, t, tm_o, 1'b0);     chk(tag, t, rst_n_o, 1'b1);
        chk(tag, t, dat_o, 1'b0);    chk(tag, t, dat_oe_o, 1'b0);
        chk(tag, t, busy_o, 1'b0);   chk(tag, t, done_o, 1'b0);
    endtask

    // abm: 0 no abort, 1 abort in the pulse train, 2 abort in the last window cycle.
    task automatic run_seq(input int mode, input int cpu, input int abm, output int first_rise, output int tp_o);
        int p, dly, win, a, tp, ab, t;
        logic [5:0] e;
        p   = (cpu == 0) ? 1 : cpu;
        dly = D50 + 256 * p;
        win = 4096 * p;
        a   = TMS + 5;
        tp  = mode ? (a + 3 + dly) : (TMS + RSTL + dly + 1);
        ab  = (abm == 1) ? tp + 20 : (abm == 2) ? tp + win - 1 : -1;
        tp_o = tp;
        first_rise = -1;
        @(negedge clk);
        cpu_per_i = CPU_W'(cpu); mode_vdd_i = mode[0]; vdd_ok_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        t = 1;
        forever begin
            if (ab >= 0 && t > ab) begin
                check_idle("R9", t);
            end else begin
                e = expv(t, mode, tp, win);
                chk("R2", t, tm_o, e[5]);
                chk(mode ? "R4" : "R3", t, rst_n_o, e[4]);
                chk((t < tp) ? "R5" : "R6", t, dat_o, e[3]);
                chk("R7", t, dat_oe_o, e[2]);
                chk("R2", t, busy_o, e[1]);
                chk("R8", t, done_o, e[0]);
            end
            if (dat_o === 1'b1 && first_rise < 0) first_rise = t;
            start_i = (t == tp + 10);          // R2: ignored while busy
            abort_i = (t == ab);
            if (t == 1) cpu_per_i = ~CPU_W'(cpu);   // R10: change after latch
            if (mode != 0 && t == a) vdd_ok_i = 1'b1;
            if (ab >= 0 && t >= ab + 3) break;
            if (t >= tp + win + 2) break;
            @(negedge clk);
            t++;
        end
        start_i = 1'b0; abort_i = 1'b0; vdd_ok_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int fr, tp;
        repeat (3) @(negedge clk);
        check_idle("R1", 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1", 0);

        run_seq(0, 1, 0, fr, tp);          // reset variant
        chk("R5", tp, fr == tp, 1'b1);
        run_seq(1, 3, 0, fr, tp);          // supply-threshold variant
        chk("R4", tp, fr == tp, 1'b1);
        run_seq(0, 0, 0, fr, tp);          // zero period behaves as one
        chk("R10", tp, fr == tp, 1'b1);
        run_seq(0, 2, 1, fr, tp);          // abort inside the pulse train
        run_seq(0, 1, 2, fr, tp);          // abort collides with window end

        // R9: start and abort in the same cycle, abort wins
        @(negedge clk);
        start_i = 1'b1; abort_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; abort_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check_idle("R9", k);
            @(negedge clk);
        end

        run_seq(0, 1, 0, fr, tp);          // recovery after aborts
        chk("R6", tp, fr == tp, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule